// File: doc/BRIEF.md
# Open-Bus Status and Controller I/O Register Block

This block is a small memory-mapped register file. A processor reads from it to get status bytes, and writes to it to drive two side-effect outputs. On a read, each register puts its live status bits into fixed positions. Every bit position the register does not define is filled from the byte most recently seen on the data bus, which is supplied from outside as `openBus`. Each register has its own mask of open-bus positions.

The block serves six register offsets:

- two serial controller data ports;
- a vertical-interrupt flag register, which also reports a fixed 4-bit chip version;
- a timer-interrupt flag register;
- a blanking and auto-poll status register;
- a general-purpose I/O port.

The two interrupt flags are held inside the block. Each is set by a pulse input and cleared as a side effect of reading it.

Writing bit 0 to the first controller port drives a latch strobe that both controllers share. Writing the I/O port so that its bit 7 falls from 1 to 0 emits a one-cycle pulse, which an outside timing generator uses to capture its beam counters. The controllers and the video timing generator are not part of this block.

Top module: `openBusStatusRegs`

## Requirements
- R1: A read at offset 0 returns `{openBus[7:2], padSerial1[1:0]}` combinationally during the cycle in which `busRd` is high.
- R2: A read at offset 1 returns `{openBus[7:5], 3'b111, padSerial2[1:0]}`.
- R3: A write at offset 0 loads `busWrData[0]` into `padLatch`, which is visible from the next cycle and held until the next such write. A write at offset 1 leaves `padLatch` unchanged.
- R4: A read at offset 2 returns `{nmiFlag, openBus[6:4], CHIP_VERSION[3:0]}`.
- R5: A read at offset 3 returns `{irqFlag, openBus[6:0]}`.
- R6: A high `nmiSet` or `irqSet` at a clock edge sets the matching flag. Reading offset 2 or 3 clears the matching flag at the edge that ends the read cycle. If a set and a clear fall in the same cycle, the set wins.
- R7: A read at offset 4 returns `autoPollBusy` in bit 0 and `openBus[5:1]` in bits 5..1.
- R8: Bit 6 of the offset 4 read is 1 exactly when `hCount <= 2` or `hCount >= 1096`.
- R9: Bit 7 of the offset 4 read is 1 exactly when `vCount >= visibleLines`.
- R10: A write at offset 5 stores the whole byte, and a read at offset 5 returns the stored byte unchanged.
- R11: `counterLatchPulse` is high for exactly the one cycle after a write at offset 5 in which the stored bit 7 was 1 and the written bit 7 is 0. It is low at all other times.
- R12: A read at offset 6 or 7 returns `openBus` unchanged. While `busRd` is low, `rdData` is 0.
- R13: After reset both flags are 0, `padLatch` and `counterLatchPulse` are 0, and the I/O port holds 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | 3 | Register offset |
| busRd | input | 1 | Read strobe; read data is valid in the same cycle |
| busWr | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| openBus | input | 8 | Last byte seen on the data bus |
| padSerial1 | input | 2 | Serial data bits from controller port 1 |
| padSerial2 | input | 2 | Serial data bits from controller port 2 |
| nmiSet | input | 1 | Sets the vertical-interrupt flag |
| irqSet | input | 1 | Sets the timer-interrupt flag |
| hCount | input | 11 | Horizontal counter |
| vCount | input | 9 | Vertical counter |
| visibleLines | input | 9 | Number of visible lines |
| autoPollBusy | input | 1 | Automatic controller polling is in progress |
| rdData | output | 8 | Read data |
| padLatch | output | 1 | Latch strobe shared by both controller ports |
| counterLatchPulse | output | 1 | One-cycle request to capture the beam counters |

## Verification
The assertions check four behaviours on every cycle:

- the latch pulse lasts a single cycle and always follows a falling write of bit 7;
- `padLatch` holds between writes at offset 0;
- each flag obeys its set and clear rules;
- a read at offset 1 always shows the three forced ones.

Only the bench's sweeps can show the full bit layout of each register. They drive every open-bus byte, every horizontal counter value across both blanking thresholds, vertical counts on each side of several visible-line settings, and the coincident set-and-read case. The sweeps also cover the full sequence of writes and read-backs of the I/O port.

// File: rtl/obsrPkg.sv
package obsrPkg;

  localparam int RegAddrW = 3;

  typedef enum logic [2:0] {
    SEL_PAD1 = 3'd0,
    SEL_PAD2 = 3'd1,
    SEL_NMI  = 3'd2,
    SEL_IRQ  = 3'd3,
    SEL_STAT = 3'd4,
    SEL_IO   = 3'd5,
    SEL_NONE = 3'd6
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    rdEn;
    regSel_e sel;
    logic    wrPad;
    logic    wrIo;
    logic    clrNmi;
    logic    clrIrq;
  } ctlStrobe_t;

endpackage

// File: rtl/obsrControl.sv
module obsrControl
  import obsrPkg::*;
(
  input  logic [RegAddrW-1:0] busAddr,
  input  logic                busRd,
  input  logic                busWr,
  output ctlStrobe_t          strb
);

  regSel_e sel;

  always_comb begin
    case (busAddr)
      3'd0:    sel = SEL_PAD1;
      3'd1:    sel = SEL_PAD2;
      3'd2:    sel = SEL_NMI;
      3'd3:    sel = SEL_IRQ;
      3'd4:    sel = SEL_STAT;
      3'd5:    sel = SEL_IO;
      default: sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strb.rdEn   = busRd;
    strb.sel    = sel;
    // only offset 0 touches the shared latch; offset 1 writes are dropped
    strb.wrPad  = busWr && (sel == SEL_PAD1);
    strb.wrIo   = busWr && (sel == SEL_IO);
    strb.clrNmi = busRd && (sel == SEL_NMI);
    strb.clrIrq = busRd && (sel == SEL_IRQ);
  end

endmodule

// File: rtl/obsrDatapath.sv
module obsrDatapath
  import obsrPkg::*;
#(
  parameter int HCNT_W       = 11,
  parameter int VCNT_W       = 9,
  parameter int HB_LO        = 2,
  parameter int HB_HI        = 1096,
  parameter int CHIP_VERSION = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [7:0]        busWrData,
  input  logic [7:0]        openBus,
  input  logic [1:0]        padSerial1,
  input  logic [1:0]        padSerial2,
  input  logic              nmiSet,
  input  logic              irqSet,
  input  logic [HCNT_W-1:0] hCount,
  input  logic [VCNT_W-1:0] vCount,
  input  logic [VCNT_W-1:0] visibleLines,
  input  logic              autoPollBusy,
  output logic [7:0]        rdData,
  output logic              padLatch,
  output logic              counterLatchPulse
);

  localparam int NumFlags = 2;
  localparam logic [HCNT_W-1:0] hbLo = HCNT_W'(HB_LO);
  localparam logic [HCNT_W-1:0] hbHi = HCNT_W'(HB_HI);
  localparam logic [3:0] verBits = 4'(CHIP_VERSION);

  logic [NumFlags-1:0] flagSet, flagClr, flagQ;
  logic [7:0] ioReg;
  logic hBlank, vBlank;

  assign flagSet = {irqSet, nmiSet};
  assign flagClr = {strb.clrIrq, strb.clrNmi};

  // interrupt flags: set wins over read-clear
  for (genvar i = 0; i < NumFlags; i++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN)           flagQ[i] <= 1'b0;
      else if (flagSet[i]) flagQ[i] <= 1'b1;
      else if (flagClr[i]) flagQ[i] <= 1'b0;
    end

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(flagClr[i] && !flagSet[i]) |-> !flagQ[i]);
    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(flagSet[i]) |-> flagQ[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      padLatch          <= 1'b0;
      ioReg             <= 8'hFF;
      counterLatchPulse <= 1'b0;
    end else begin
      if (strb.wrPad) padLatch <= busWrData[0];
      if (strb.wrIo)  ioReg    <= busWrData;
      counterLatchPulse <= strb.wrIo && ioReg[7] && !busWrData[7];
    end
  end

  // R3
  pad_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.wrPad) |-> $stable(padLatch));
  // R11
  latch_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    counterLatchPulse |=> !counterLatchPulse);
  // R11
  latch_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    counterLatchPulse |-> ($past(strb.wrIo) && $past(ioReg[7]) && !ioReg[7]));

  assign hBlank = (hCount <= hbLo) || (hCount >= hbHi);
  assign vBlank = (vCount >= visibleLines);

  always_comb begin
    rdData = 8'h00;
    if (strb.rdEn) begin
      case (strb.sel)
        SEL_PAD1: rdData = {openBus[7:2], padSerial1};
        SEL_PAD2: rdData = {openBus[7:5], 3'b111, padSerial2};
        SEL_NMI:  rdData = {flagQ[0], openBus[6:4], verBits};
        SEL_IRQ:  rdData = {flagQ[1], openBus[6:0]};
        SEL_STAT: rdData = {vBlank, hBlank, openBus[5:1], autoPollBusy};
        SEL_IO:   rdData = ioReg;
        default:  rdData = openBus;
      endcase
    end
  end

endmodule

// File: rtl/openBusStatusRegs.sv
module openBusStatusRegs
  import obsrPkg::*;
#(
  parameter int HCNT_W       = 11,
  parameter int VCNT_W       = 9,
  parameter int HB_LO        = 2,
  parameter int HB_HI        = 1096,
  parameter int CHIP_VERSION = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [7:0]        busWrData,
  input  logic [7:0]        openBus,
  input  logic [1:0]        padSerial1,
  input  logic [1:0]        padSerial2,
  input  logic              nmiSet,
  input  logic              irqSet,
  input  logic [HCNT_W-1:0] hCount,
  input  logic [VCNT_W-1:0] vCount,
  input  logic [VCNT_W-1:0] visibleLines,
  input  logic              autoPollBusy,
  output logic [7:0]        rdData,
  output logic              padLatch,
  output logic              counterLatchPulse
);

  ctlStrobe_t strb;

  obsrControl uCtl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .strb    (strb)
  );

  obsrDatapath #(
    .HCNT_W       (HCNT_W),
    .VCNT_W       (VCNT_W),
    .HB_LO        (HB_LO),
    .HB_HI        (HB_HI),
    .CHIP_VERSION (CHIP_VERSION)
  ) uDp (
    .clk               (clk),
    .rstN              (rstN),
    .strb              (strb),
    .busWrData         (busWrData),
    .openBus           (openBus),
    .padSerial1        (padSerial1),
    .padSerial2        (padSerial2),
    .nmiSet            (nmiSet),
    .irqSet            (irqSet),
    .hCount            (hCount),
    .vCount            (vCount),
    .visibleLines      (visibleLines),
    .autoPollBusy      (autoPollBusy),
    .rdData            (rdData),
    .padLatch          (padLatch),
    .counterLatchPulse (counterLatchPulse)
  );

  // R2
  pad2_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 3'd1) |-> (rdData[4:2] == 3'b111));

endmodule

// File: tb/openBusStatusRegs_test.sv
module openBusStatusRegs_test;

  localparam int VER = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [7:0]  busWrData = '0, openBus = '0;
  logic [1:0]  padSerial1 = '0, padSerial2 = '0;
  logic        nmiSet = 1'b0, irqSet = 1'b0;
  logic [10:0] hCount = '0;
  logic [8:0]  vCount = '0, visibleLines = 9'd224;
  logic        autoPollBusy = 1'b0;
  logic [7:0]  rdData;
  logic        padLatch, counterLatchPulse;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  openBusStatusRegs uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWrData(busWrData), .openBus(openBus), .padSerial1(padSerial1),
    .padSerial2(padSerial2), .nmiSet(nmiSet), .irqSet(irqSet), .hCount(hCount),
    .vCount(vCount), .visibleLines(visibleLines), .autoPollBusy(autoPollBusy),
    .rdData(rdData), .padLatch(padLatch), .counterLatchPulse(counterLatchPulse)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic rdReg(input logic [2:0] a, output logic [7:0] v);
    busAddr = a; busRd = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    busAddr = a; busWr = 1'b1; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic pulseSet(input bit isIrq);
    if (isIrq) irqSet = 1'b1; else nmiSet = 1'b1;
    @(negedge clk);
    irqSet = 1'b0; nmiSet = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] prevIo;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk("R13 padLatch", {7'd0, padLatch}, 8'h00);
    chk("R13 pulse", {7'd0, counterLatchPulse}, 8'h00);
    chk("R12 idle rdData", rdData, 8'h00);
    rdReg(3'd2, v); chk("R13 nmi flag", {7'd0, v[7]}, 8'h00);
    rdReg(3'd3, v); chk("R13 irq flag", {7'd0, v[7]}, 8'h00);
    rdReg(3'd5, v); chk("R13 io reset", v, 8'hFF);

    // R1 R2 sweeps of open bus and serial bits
    for (int ob = 0; ob < 256; ob++) begin
      for (int p = 0; p < 4; p++) begin
        openBus = 8'(ob); padSerial1 = 2'(p); padSerial2 = 2'(3 - p);
        rdReg(3'd0, v); chk("R1 pad1", v, {8'(ob) & 8'hFC} | 8'(p));
        rdReg(3'd1, v); chk("R2 pad2", v, (8'(ob) & 8'hE0) | 8'h1C | 8'(3 - p));
      end
      // R4 R5 R12 with flags clear
      rdReg(3'd2, v); chk("R4 nmi reg", v, (8'(ob) & 8'h70) | 8'(VER));
      rdReg(3'd3, v); chk("R5 irq reg", v, 8'(ob) & 8'h7F);
      rdReg(3'd6, v); chk("R12 offset6", v, 8'(ob));
      rdReg(3'd7, v); chk("R12 offset7", v, 8'(ob));
    end

    // R6 flag set, read, cleared
    openBus = 8'h5A;
    for (int f = 0; f < 2; f++) begin
      pulseSet(f[0]);
      rdReg(f[0] ? 3'd3 : 3'd2, v);
      chk(f ? "R5 irq set" : "R4 nmi set", v,
          f ? 8'hDA : (8'h80 | (8'h5A & 8'h70) | 8'(VER)));
      rdReg(f[0] ? 3'd3 : 3'd2, v); chk("R6 cleared", {7'd0, v[7]}, 8'h00);
      // coincident set and read: set wins
      if (f == 0) nmiSet = 1'b1; else irqSet = 1'b1;
      rdReg(f[0] ? 3'd3 : 3'd2, v);
      nmiSet = 1'b0; irqSet = 1'b0;
      chk("R6 set during read", {7'd0, v[7]}, 8'h00);
      rdReg(f[0] ? 3'd3 : 3'd2, v); chk("R6 set wins", {7'd0, v[7]}, 8'h01 << 0 << 7 >> 7);
      rdReg(f[0] ? 3'd3 : 3'd2, v); chk("R6 cleared again", {7'd0, v[7]}, 8'h00);
    end

    // R7 R8 sweep horizontal counter
    vCount = 9'd0; visibleLines = 9'd224;
    for (int h = 0; h < 2048; h++) begin
      hCount = 11'(h); openBus = 8'(h * 7); autoPollBusy = h[0] ^ h[3];
      rdReg(3'd4, v);
      chk("R8 hblank", {7'd0, v[6]}, {7'd0, (h <= 2) || (h >= 1096)});
      chk("R7 status low", v & 8'h3F, (8'(h * 7) & 8'h3E) | {7'd0, h[0] ^ h[3]});
      chk("R9 no vblank", {7'd0, v[7]}, 8'h00);
    end

    // R9 sweep vertical counter against several line counts
    hCount = 11'd500;
    for (int s = 0; s < 3; s++) begin
      visibleLines = (s == 0) ? 9'd224 : (s == 1) ? 9'd239 : 9'd0;
      for (int vc = 0; vc < 512; vc++) begin
        vCount = 9'(vc);
        rdReg(3'd4, v);
        chk("R9 vblank", {7'd0, v[7]}, {7'd0, vc >= int'(visibleLines)});
      end
    end

    // R3 latch strobe
    for (int d = 0; d < 8; d++) begin
      wrReg(3'd0, 8'(d * 37));
      chk("R3 latch from offset0", {7'd0, padLatch}, {7'd0, 1'(d * 37)});
      wrReg(3'd1, ~8'(d * 37));
      chk("R3 offset1 ignored", {7'd0, padLatch}, {7'd0, 1'(d * 37)});
    end

    // R10 R11 io port sweep
    prevIo = 8'hFF;
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dv;
      dv = 8'((d * 73) ^ (d >> 1));
      wrReg(3'd5, dv);
      chk("R11 pulse", {7'd0, counterLatchPulse}, {7'd0, prevIo[7] && !dv[7]});
      rdReg(3'd5, v);
      chk("R10 readback", v, dv);
      chk("R11 pulse ends", {7'd0, counterLatchPulse}, 8'h00);
      prevIo = dv;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule